// File: doc/BRIEF.md
# Key-Locked Fuse Controller Register Front End

This block is the 32-bit software-facing register slice of a one-time-programmable fuse controller. It owns a write-protection latch that blocks every register write until a 16-bit unlock key has been written. It also holds six write-1-to-clear interrupt status bits that hardware event pulses set, and an interrupt mask. Software cannot write the mask directly; it changes it through a set register and a clear register. The block combines status and mask into one level-sensitive interrupt line.

The bus is a plain request port with valid, write, byte address and write data. Reads return the addressed value combinationally in the same cycle as the request. Writes take effect on the clock edge that samples them. The fuse array, its timing controls and its shadow copies sit outside this block.

Top module: `efc_regfront`

## Requirements
- R1: After reset the lock register (offset 0x00) reads 1, the status register (0x30) reads 0, the mask register (0x34) reads 0x8000001F, and the interrupt output is low.
- R2: A write to offset 0x00 with data exactly 0x0000DF0D stores 0 (unlocked). A write there with any other 32-bit value, including 0x0001DF0D, stores 1 (locked). Writes to 0x00 are accepted whether or not the block is locked.
- R3: While the lock register holds 1, a write to any offset other than 0x00 changes no register.
- R4: Each pulse on `hw_event` sets one status bit at the edge that samples it: event bit 0 sets status bit 0 (program done), bit 1 sets status bit 1 (program error), bit 2 sets status bit 2 (read done), bit 3 sets status bit 3 (read error), bit 4 sets status bit 4 (cache error), and bit 5 sets status bit 31 (bus slave error).
- R5: While unlocked, writing 1 to a status bit at 0x30 clears that bit, and writing 0 leaves it unchanged. The reserved status bits 30..5 always read 0.
- R6: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Writes to the mask register at 0x34 have no effect.
- R8: While unlocked, a write to 0x38 ORs the written bits into the mask, and a write to 0x3C clears the written bits from the mask. Only mask bits 31 and 4..0 exist. Offsets 0x38 and 0x3C read 0.
- R9: The interrupt output is high exactly when the status AND the mask is nonzero. It follows the register state from the same clock edge.
- R10: An access whose address is not one of the mapped word offsets, including any address with bits 1..0 nonzero, writes nothing and reads 0. With no valid read request, the read data is 0.
- R11: The lock register reads its stored state in bit 0, with bits 31..1 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| hw_event | input | 6 | Event pulses that set status bits |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due combinationally in the cycle of the request. Register updates from writes and event pulses become visible at the next rising edge, and the interrupt line changes on that same edge because it is registered from the next-state values. The bench drives inputs one time step after a rising edge. It advances its behavioural model on each rising edge and compares read data and the interrupt line at every falling edge. Every result is therefore checked half a cycle after it is due, and never at an edge.

// File: rtl/efc_reg_pkg.sv
package efc_reg_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_SRC = 6;

    localparam logic [DATA_W-1:0] OFS_LOCK  = 32'h00;
    localparam logic [DATA_W-1:0] OFS_STAT  = 32'h30;
    localparam logic [DATA_W-1:0] OFS_MASK  = 32'h34;
    localparam logic [DATA_W-1:0] OFS_SET   = 32'h38;
    localparam logic [DATA_W-1:0] OFS_CLR   = 32'h3C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_DF0D;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam src_vec_t MASK_RESET = '1;

    typedef struct packed {
        logic wr_lock;
        logic wr_stat;
        logic wr_mask;
        logic wr_set;
        logic wr_clr;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_LOCK,
        RD_STAT,
        RD_MASK,
        RD_ZERO
    } rd_sel_e;

    // Register bit position of source i: the last source sits at the top bit.
    function automatic int unsigned src_pos(input int unsigned i);
        return (i == NUM_SRC - 1) ? DATA_W - 1 : i;
    endfunction

    function automatic logic [DATA_W-1:0] src_expand(input src_vec_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            w[src_pos(i)] = v[i];
        end
        return w;
    endfunction

    function automatic src_vec_t src_compress(input logic [DATA_W-1:0] w);
        src_vec_t v;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            v[i] = w[src_pos(i)];
        end
        return v;
    endfunction

endpackage

// File: rtl/efc_bus_decode.sv
module efc_bus_decode
    import efc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_strobe_t        wr_o,
    output rd_sel_e           rd_sel_o
);

    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    logic wr_req;
    logic rd_req;

    always_comb begin
        wr_req = bus_valid && bus_write;
        rd_req = bus_valid && !bus_write;

        wr_o.wr_lock = wr_req && (bus_addr == A_LOCK);
        wr_o.wr_stat = wr_req && (bus_addr == A_STAT);
        wr_o.wr_mask = wr_req && (bus_addr == A_MASK);
        wr_o.wr_set  = wr_req && (bus_addr == A_SET);
        wr_o.wr_clr  = wr_req && (bus_addr == A_CLR);

        rd_sel_o = RD_NONE;
        if (rd_req) begin
            unique case (bus_addr)
                A_LOCK:  rd_sel_o = RD_LOCK;
                A_STAT:  rd_sel_o = RD_STAT;
                A_MASK:  rd_sel_o = RD_MASK;
                default: rd_sel_o = RD_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/efc_lock.sv
module efc_lock
    import efc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked_o
);

    typedef struct packed {
        logic locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lock) begin
            st_d.locked = (wdata != UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wdata == UNLOCK_KEY) |=> !locked_o);

    assert_bad_key_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wdata != UNLOCK_KEY) |=> locked_o);

endmodule

// File: rtl/efc_irq_ctrl.sv
module efc_irq_ctrl
    import efc_reg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_stat,
    input  logic     wr_set,
    input  logic     wr_clr,
    input  src_vec_t wbits,
    input  src_vec_t hw_event,
    output src_vec_t stat_o,
    output src_vec_t mask_o,
    output logic     irq_o
);

    typedef struct packed {
        src_vec_t stat;
        src_vec_t mask;
        logic     irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then set: an event beats a same-cycle clear.
        if (wr_stat) begin
            st_d.stat = st_q.stat & ~wbits;
        end
        if (wr_set) begin
            st_d.mask = st_q.mask | wbits;
        end
        if (wr_clr) begin
            st_d.mask = st_q.mask & ~wbits;
        end
        st_d.stat = st_d.stat | hw_event;
        st_d.irq  = |(st_d.stat & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= MASK_RESET;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

    assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != '0) |=> ((stat_o & $past(hw_event)) == $past(hw_event)));

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && hw_event == '0) |=> ((stat_o & $past(wbits)) == '0));

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (wbits & hw_event) != '0) |=> ((stat_o & $past(wbits & hw_event)) != '0));

    assert_set_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_o & $past(wbits)) == $past(wbits)));

    assert_clr_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_o & $past(wbits)) == '0));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(hw_event != '0 || wr_set));

endmodule

// File: rtl/efc_regfront.sv
module efc_regfront
    import efc_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        hw_event,
    output logic              irq
);

    wr_strobe_t wr_raw;
    rd_sel_e    rd_sel;
    logic       locked;
    src_vec_t   stat_v;
    src_vec_t   mask_v;
    src_vec_t   wbits;
    logic       wr_stat_g;
    logic       wr_set_g;
    logic       wr_clr_g;

    efc_bus_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_o      (wr_raw),
        .rd_sel_o  (rd_sel)
    );

    efc_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lock  (wr_raw.wr_lock),
        .wdata    (bus_wdata),
        .locked_o (locked)
    );

    always_comb begin
        wbits     = src_compress(bus_wdata);
        wr_stat_g = wr_raw.wr_stat && !locked;
        wr_set_g  = wr_raw.wr_set  && !locked;
        wr_clr_g  = wr_raw.wr_clr  && !locked;
    end

    efc_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stat  (wr_stat_g),
        .wr_set   (wr_set_g),
        .wr_clr   (wr_clr_g),
        .wbits    (wbits),
        .hw_event (hw_event),
        .stat_o   (stat_v),
        .mask_o   (mask_v),
        .irq_o    (irq)
    );

    always_comb begin
        unique case (rd_sel)
            RD_LOCK: bus_rdata = {31'b0, locked};
            RD_STAT: bus_rdata = src_expand(stat_v);
            RD_MASK: bus_rdata = src_expand(mask_v);
            default: bus_rdata = '0;
        endcase
    end

    assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && locked && bus_addr != ADDR_W'(OFS_LOCK) && hw_event == '0)
        |=> ($stable(stat_v) && $stable(mask_v) && locked));

    assert_mask_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask_v));

    assert_unaligned_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr[1:0] != 2'b00 && hw_event == '0)
        |=> ($stable(stat_v) && $stable(mask_v) && $stable(locked)));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_rdata == '0));

endmodule

// File: tb/efc_regfront_test.sv
`timescale 1ns/1ps
module efc_regfront_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  hw_event = '0;
    logic        irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R10";

    // behavioural reference state
    bit        m_lock;
    bit [31:0] m_stat;
    bit [31:0] m_mask;

    localparam bit [31:0] IMPL = 32'h8000_001F;

    always #4 clk = ~clk;

    efc_regfront #(.ADDR_W(8)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_event  (hw_event),
        .irq       (irq)
    );

    function automatic bit [31:0] ev_to_bits(input bit [5:0] e);
        bit [31:0] r = '0;
        r[4:0] = e[4:0];
        r[31]  = e[5];
        return r;
    endfunction

    function automatic bit [31:0] model_read();
        if (!bus_valid || bus_write) return 32'h0;
        case (bus_addr)
            8'h00:   return {31'b0, m_lock};
            8'h30:   return m_stat;
            8'h34:   return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lock = 1'b1;
            m_stat = '0;
            m_mask = IMPL;
        end else begin
            if (bus_valid && bus_write) begin
                if (bus_addr == 8'h00) begin
                    m_lock = (bus_wdata != 32'h0000_DF0D);
                end else if (!m_lock) begin
                    case (bus_addr)
                        8'h30: m_stat = m_stat & ~(bus_wdata & IMPL);
                        8'h38: m_mask = m_mask | (bus_wdata & IMPL);
                        8'h3C: m_mask = m_mask & ~(bus_wdata & IMPL);
                        default: ;
                    endcase
                end
            end
            m_stat = m_stat | ev_to_bits(hw_event);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_tag, bus_rdata, model_read());
            check("R9", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
        end
    end

    task automatic drive(input bit v, input bit w, input bit [7:0] a,
                         input bit [31:0] d, input bit [5:0] e, input string tag);
        @(posedge clk);
        #1;
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        hw_event  = e;
        cur_tag   = tag;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        drive(1'b1, 1'b1, a, d, 6'h0, tag);
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        drive(1'b1, 1'b0, a, 32'h0, 6'h0, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 1'b0, 8'h0, 32'h0, 6'h0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        rd(8'h00, "R1"); rd(8'h30, "R1"); rd(8'h34, "R1");
        // R3 writes dropped while locked
        wr(8'h3C, 32'hFFFF_FFFF, "R3"); rd(8'h34, "R3");
        drive(1'b0, 1'b0, 8'h0, 32'h0, 6'h01, "R4"); // raise status bit 0
        wr(8'h30, 32'h0000_0001, "R3"); rd(8'h30, "R3");
        // R2 wrong key keeps lock, near-miss key too
        wr(8'h00, 32'h0000_1234, "R2"); rd(8'h00, "R2");
        wr(8'h00, 32'h0001_DF0D, "R2"); rd(8'h00, "R2");
        wr(8'h00, 32'h0000_DF0D, "R2"); rd(8'h00, "R11");
        // R4 each event source
        for (int i = 1; i < 6; i++) begin
            drive(1'b0, 1'b0, 8'h0, 32'h0, 6'(1 << i), "R4");
            rd(8'h30, "R4");
        end
        // R5 write-1-to-clear, zeros leave bits, reserved stays 0
        wr(8'h30, 32'h7FFF_FFE0, "R5"); rd(8'h30, "R5");
        wr(8'h30, 32'h0000_0005, "R5"); rd(8'h30, "R5");
        // R6 event and clear on the same bit
        drive(1'b1, 1'b1, 8'h30, 32'h8000_0002, 6'h02, "R6"); rd(8'h30, "R6");
        // R7 mask read-only
        wr(8'h34, 32'h0, "R7"); rd(8'h34, "R7");
        // R8 disable/enable and readback zero
        wr(8'h3C, 32'hFFFF_FFFF, "R8"); rd(8'h34, "R8"); idle("R9");
        wr(8'h38, 32'h0000_0008, "R8"); rd(8'h34, "R8");
        rd(8'h38, "R8"); rd(8'h3C, "R8");
        wr(8'h30, 32'hFFFF_FFFF, "R9"); idle("R9");
        drive(1'b0, 1'b0, 8'h0, 32'h0, 6'h01, "R9"); idle("R9");
        drive(1'b0, 1'b0, 8'h0, 32'h0, 6'h08, "R9"); idle("R9");
        wr(8'h3C, 32'h0000_0008, "R9"); idle("R9");
        wr(8'h38, 32'hFFFF_FFFF, "R8"); rd(8'h34, "R8");
        // R10 unaligned and unmapped
        wr(8'h32, 32'hFFFF_FFFF, "R10"); rd(8'h30, "R10");
        wr(8'h3D, 32'hFFFF_FFFF, "R10"); rd(8'h34, "R10");
        wr(8'h01, 32'h0000_0001, "R10"); rd(8'h00, "R10");
        rd(8'h31, "R10"); rd(8'h20, "R10"); rd(8'hFC, "R10");
        // relock, then status write dropped again
        wr(8'h00, 32'h0, "R2"); rd(8'h00, "R11");
        wr(8'h30, 32'hFFFF_FFFF, "R3"); rd(8'h30, "R3");
        idle("R10"); idle("R10");
        @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule